// File: doc/BRIEF.md
# Segment Table Address Translator

The block turns each virtual address into a physical address through a small table of segments. Every segment has its own base address, its own bound (the segment's length), a flag that marks it in use, and a flag that allows writes. The top bits of the virtual address pick the segment. The remaining bits are the offset within it. A legal access returns base plus offset. An illegal access returns a fault and a code that says why it failed.

Requests arrive with a valid strobe and a read/write flag. The result appears one clock later. The table is programmed one entry per cycle through a separate port. That port takes effect only while the kernel-mode input is high, so code running in user mode cannot change its own mappings. After reset every segment is unused, and every access faults until the table has been set up.

Top module: `seg_xlate`

## Requirements
- R1: The segment number is virtual address bits [15:14] and the offset is bits [13:0].
- R2: A request that raises no fault gives, on the following clock, rspValid=1, rspFault=0, rspCause=2'b00 and rspPaddr = (base + offset) mod 2^16.
- R3: An offset greater than or equal to the segment's bound gives rspFault=1, rspCause=2'b01 and rspPaddr=0.
- R4: An access to a segment that is not marked in use gives rspFault=1 and rspCause=2'b10. This check has priority over the bound check and the protection check.
- R5: A write (reqWrite=1) to a segment whose writable flag is 0 gives rspFault=1 and rspCause=2'b11, but only when the offset is within the bound. A bound violation reports 2'b01 instead. Reads from such a segment translate normally.
- R6: A table write (cfgWrEn=1) updates entry cfgSeg only when kernelMode=1. With kernelMode=0 the table does not change.
- R7: After reset every segment is unused and rspValid=0.
- R8: A request in the same cycle as a table write to the same entry is translated with the old entry contents. The new contents apply from the next request onward.
- R9: In a cycle after which no request was taken, rspValid=0, rspFault=0, rspCause=2'b00 and rspPaddr=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kernelMode | input | 1 | High while privileged code runs; gates table writes |
| cfgWrEn | input | 1 | Table write strobe |
| cfgSeg | input | 2 | Entry to write |
| cfgBase | input | 16 | New base address |
| cfgBound | input | 15 | New bound (segment length, up to 0x4000) |
| cfgUsed | input | 1 | New in-use flag |
| cfgWritable | input | 1 | New write-permission flag |
| reqValid | input | 1 | Translation request strobe |
| reqAddr | input | 16 | Virtual address |
| reqWrite | input | 1 | 1 = write access, 0 = read access |
| rspValid | output | 1 | Result valid, one cycle after the request |
| rspPaddr | output | 16 | Physical address, 0 on a fault |
| rspFault | output | 1 | Access refused |
| rspCause | output | 2 | 00 none, 01 bound, 10 unused segment, 11 protection |

## Verification
A table write and a translation request can occur in the same cycle, and both can target the same entry. The bench provokes this by driving a kernel-mode write that enables a previously unused segment in the same cycle as a request to that segment. It expects an unused-segment fault for that request, and then the new base on the next request. User-mode writes are also issued in the same cycle as other traffic. They are judged by translating the entry they tried to change and confirming that the old mapping still holds.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  parameter int VA_W  = 16;
  parameter int SEG_W = 2;
  parameter int PA_W  = 16;
  localparam int OFF_W = VA_W - SEG_W;
  localparam int NSEG  = 1 << SEG_W;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'b00,
    CAUSE_BOUND  = 2'b01,
    CAUSE_UNUSED = 2'b10,
    CAUSE_PROT   = 2'b11
  } fault_cause_e;

  typedef struct packed {
    logic             used;
    logic             writable;
    logic [PA_W-1:0]  base;
    logic [OFF_W:0]   bound;
  } seg_entry_t;

  typedef struct packed {
    logic tblWr;
    logic reqTake;
  } ctl_strobe_t;
endpackage

// File: rtl/seg_xlate_ctrl.sv
module seg_xlate_ctrl
  import seg_xlate_pkg::*;
(
  input  logic        kernelMode,
  input  logic        cfgWrEn,
  input  logic        reqValid,
  output ctl_strobe_t strb
);
  always_comb begin
    strb.tblWr   = cfgWrEn && kernelMode;
    strb.reqTake = reqValid;
  end
endmodule

// File: rtl/seg_xlate_dp.sv
module seg_xlate_dp
  import seg_xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_strobe_t       strb,
  input  logic [SEG_W-1:0]  cfgSeg,
  input  seg_entry_t        cfgEntry,
  input  logic [VA_W-1:0]   reqAddr,
  input  logic              reqWrite,
  output logic              rspValid,
  output logic [PA_W-1:0]   rspPaddr,
  output logic              rspFault,
  output fault_cause_e      rspCause
);
  seg_entry_t [NSEG-1:0] tbl;

  for (genvar g = 0; g < NSEG; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tbl[g] <= '0;
      end else if (strb.tblWr && (cfgSeg == SEG_W'(g))) begin
        tbl[g] <= cfgEntry;
      end
    end
  end

  logic [SEG_W-1:0] segIdx;
  logic [OFF_W-1:0] offset;
  seg_entry_t       curEnt;
  logic [PA_W-1:0]  sumAddr;
  fault_cause_e     nextCause;

  always_comb begin
    segIdx  = reqAddr[VA_W-1 -: SEG_W];
    offset  = reqAddr[OFF_W-1:0];
    curEnt  = tbl[segIdx];
    sumAddr = curEnt.base + PA_W'(offset);
    if (!curEnt.used)                        nextCause = CAUSE_UNUSED;
    else if ({1'b0, offset} >= curEnt.bound) nextCause = CAUSE_BOUND;
    else if (reqWrite && !curEnt.writable)   nextCause = CAUSE_PROT;
    else                                     nextCause = CAUSE_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !strb.reqTake) begin
      rspValid <= 1'b0;
      rspPaddr <= '0;
      rspFault <= 1'b0;
      rspCause <= CAUSE_NONE;
    end else begin
      rspValid <= 1'b1;
      rspFault <= (nextCause != CAUSE_NONE);
      rspCause <= nextCause;
      rspPaddr <= (nextCause == CAUSE_NONE) ? sumAddr : '0;
    end
  end

  // R6
  tbl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.tblWr |=> $stable(tbl));
  // R2
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.reqTake |=> rspValid);
  // R9
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.reqTake |=> (!rspValid && !rspFault && rspPaddr == '0));
  // R3
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rspFault |-> (rspValid && rspPaddr == '0));
  // R2
  ok_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && !rspFault) |-> (rspCause == CAUSE_NONE));
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kernelMode,
  input  logic              cfgWrEn,
  input  logic [SEG_W-1:0]  cfgSeg,
  input  logic [PA_W-1:0]   cfgBase,
  input  logic [OFF_W:0]    cfgBound,
  input  logic              cfgUsed,
  input  logic              cfgWritable,
  input  logic              reqValid,
  input  logic [VA_W-1:0]   reqAddr,
  input  logic              reqWrite,
  output logic              rspValid,
  output logic [PA_W-1:0]   rspPaddr,
  output logic              rspFault,
  output logic [1:0]        rspCause
);
  ctl_strobe_t  strb;
  seg_entry_t   cfgEntry;
  fault_cause_e causeE;

  assign cfgEntry = '{used: cfgUsed, writable: cfgWritable, base: cfgBase, bound: cfgBound};
  assign rspCause = causeE;

  seg_xlate_ctrl u_ctrl (
    .kernelMode (kernelMode),
    .cfgWrEn    (cfgWrEn),
    .reqValid   (reqValid),
    .strb       (strb)
  );

  seg_xlate_dp u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .cfgSeg   (cfgSeg),
    .cfgEntry (cfgEntry),
    .reqAddr  (reqAddr),
    .reqWrite (reqWrite),
    .rspValid (rspValid),
    .rspPaddr (rspPaddr),
    .rspFault (rspFault),
    .rspCause (causeE)
  );
endmodule

// File: tb/seg_xlate_tb.sv
`timescale 1ns/1ps
module seg_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        kernelMode = 1'b0, cfgWrEn = 1'b0, cfgUsed = 1'b0, cfgWritable = 1'b0;
  logic [1:0]  cfgSeg = '0;
  logic [15:0] cfgBase = '0;
  logic [14:0] cfgBound = '0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic        rspValid, rspFault;
  logic [15:0] rspPaddr;
  logic [1:0]  rspCause;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  seg_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .kernelMode(kernelMode), .cfgWrEn(cfgWrEn),
    .cfgSeg(cfgSeg), .cfgBase(cfgBase), .cfgBound(cfgBound), .cfgUsed(cfgUsed),
    .cfgWritable(cfgWritable), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .rspValid(rspValid), .rspPaddr(rspPaddr),
    .rspFault(rspFault), .rspCause(rspCause)
  );

  task automatic expect_rsp(string req, logic v, logic f, logic [1:0] c, logic [15:0] pa);
    checks++;
    if (rspValid !== v || rspFault !== f || rspCause !== c || rspPaddr !== pa) begin
      failures++;
      $display("FAIL %s: got v=%0b f=%0b c=%0d pa=%h, expected v=%0b f=%0b c=%0d pa=%h",
               req, rspValid, rspFault, rspCause, rspPaddr, v, f, c, pa);
    end
  endtask

  task automatic set_cfg(logic k, logic [1:0] s, logic [15:0] b, logic [14:0] bd, logic u, logic w);
    kernelMode = k; cfgWrEn = 1'b1; cfgSeg = s; cfgBase = b;
    cfgBound = bd; cfgUsed = u; cfgWritable = w;
  endtask

  task automatic write_entry(logic k, logic [1:0] s, logic [15:0] b, logic [14:0] bd, logic u, logic w);
    @(negedge clk);
    set_cfg(k, s, b, bd, u, w);
    @(negedge clk);
    cfgWrEn = 1'b0; kernelMode = 1'b0;
  endtask

  task automatic xlate(string req, logic [1:0] s, logic [13:0] off, logic wr,
                       logic f, logic [1:0] c, logic [15:0] pa);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = {s, off}; reqWrite = wr;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
    expect_rsp(req, 1'b1, f, c, pa);
  endtask

  task automatic t_reset;
    @(negedge clk);
    expect_rsp("R7 reset idle", 1'b0, 1'b0, 2'b00, 16'h0);
    xlate("R7 seg1 unused after reset", 2'd1, 14'h0, 1'b0, 1'b1, 2'b10, 16'h0);
    xlate("R7 seg3 unused after reset", 2'd3, 14'h10, 1'b1, 1'b1, 2'b10, 16'h0);
  endtask

  task automatic t_user_write_blocked;
    write_entry(1'b0, 2'd0, 16'h4000, 15'h700, 1'b1, 1'b0);
    xlate("R6 user write ignored", 2'd0, 14'h10, 1'b0, 1'b1, 2'b10, 16'h0);
  endtask

  task automatic t_program;
    write_entry(1'b1, 2'd0, 16'h4000, 15'h0700, 1'b1, 1'b0);
    write_entry(1'b1, 2'd1, 16'h0000, 15'h0500, 1'b1, 1'b1);
    write_entry(1'b1, 2'd3, 16'h2000, 15'h1000, 1'b1, 1'b1);
  endtask

  task automatic t_translate;
    xlate("R2 (3,fff)->2fff", 2'd3, 14'hfff, 1'b0, 1'b0, 2'b00, 16'h2fff);
    xlate("R1 (1,4ff)->04ff", 2'd1, 14'h4ff, 1'b1, 1'b0, 2'b00, 16'h04ff);
    xlate("R5 read of read-only seg0", 2'd0, 14'h6ff, 1'b0, 1'b0, 2'b00, 16'h46ff);
    xlate("R1 (0,0)->4000", 2'd0, 14'h0, 1'b0, 1'b0, 2'b00, 16'h4000);
  endtask

  task automatic t_faults;
    xlate("R3 (3,1000) at bound", 2'd3, 14'h1000, 1'b0, 1'b1, 2'b01, 16'h0);
    xlate("R3 (0,700) at bound", 2'd0, 14'h700, 1'b0, 1'b1, 2'b01, 16'h0);
    xlate("R3 (1,3fff) far past bound", 2'd1, 14'h3fff, 1'b1, 1'b1, 2'b01, 16'h0);
    xlate("R5 write read-only seg0", 2'd0, 14'h10, 1'b1, 1'b1, 2'b11, 16'h0);
    xlate("R5 bound beats protection", 2'd0, 14'h700, 1'b1, 1'b1, 2'b01, 16'h0);
    xlate("R4 seg2 unused", 2'd2, 14'h5, 1'b1, 1'b1, 2'b10, 16'h0);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    set_cfg(1'b1, 2'd2, 16'h1000, 15'h0100, 1'b1, 1'b1);
    reqValid = 1'b1; reqAddr = {2'd2, 14'h5}; reqWrite = 1'b0;
    @(negedge clk);
    cfgWrEn = 1'b0; kernelMode = 1'b0; reqValid = 1'b0;
    expect_rsp("R8 same-cycle uses old entry", 1'b1, 1'b1, 2'b10, 16'h0);
    xlate("R8 new entry applies next", 2'd2, 14'h5, 1'b0, 1'b0, 2'b00, 16'h1005);
    @(negedge clk);
    set_cfg(1'b0, 2'd3, 16'h0000, 15'h0001, 1'b0, 1'b0);
    reqValid = 1'b1; reqAddr = {2'd3, 14'h0}; reqWrite = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0; reqValid = 1'b0; reqWrite = 1'b0;
    expect_rsp("R6 user write with request", 1'b1, 1'b0, 2'b00, 16'h2000);
    xlate("R6 seg3 kept after user write", 2'd3, 14'h2, 1'b1, 1'b0, 2'b00, 16'h2002);
  endtask

  task automatic t_wrap_idle;
    write_entry(1'b1, 2'd1, 16'hff00, 15'h4000, 1'b1, 1'b1);
    xlate("R2 base+offset wraps", 2'd1, 14'h200, 1'b0, 1'b0, 2'b00, 16'h0100);
    xlate("R3 full-size seg top offset", 2'd1, 14'h3fff, 1'b1, 1'b0, 2'b00, 16'h3eff);
    @(negedge clk);
    expect_rsp("R9 idle after request", 1'b0, 1'b0, 2'b00, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_user_write_blocked();
    t_program();
    t_translate();
    t_faults();
    t_same_cycle();
    t_wrap_idle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule